// File: doc/BRIEF.md
# Security Module Operational State Controller

This block sequences a cryptographic module through its operational life: powered off, power-on, power-up self-test, user service, fatal error and return-for-analysis. When the module is powered on it runs a set of known-answer tests in a fixed order, with no operator action. Each test is passed or failed by comparing the result that the algorithm engine computed with the expected value that was stored for it. Services are offered only after every test has passed. The first mismatch stops the sequence and latches a fatal error code. The algorithm engines sit outside the block. They appear only as a test index going out and a done/result/expected handshake coming back.

While the module is in user state, three events can move it elsewhere. A failure strobe from any conditional (continuous) test latches a fatal error. A return-for-analysis request parks the module permanently. A mode-change request wipes all stored secrets for a fixed number of cycles, then updates the mode, then reboots the module through the self-tests. Data input and data output are enabled only in user state. A single-slot service gate accepts one request at a time and holds a busy flag until that request reports completion.

Top module: `secmod_state_ctrl`

## Requirements
- R1: After a synchronous active-low reset the block is in the powered-off state. The state codes are off=0, power-on=1, self-test=2, user=3, error=4, return-for-analysis=5 and secret-clear=6. After reset the status code is 0, both data enables and the busy flag are low, and the mode output is 0.
- R2: A start pulse in the off state moves the block to power-on for exactly one cycle and then to self-test without further input. In power-on and self-test, both data enables stay low and no service request is accepted.
- R3: Tests run in index order, from 0 to NUM_TESTS-1, and the index is shown on kat_idx_o while kat_run_o is high. A test passes only when kat_result_i equals kat_expect_i at the cycle where kat_done_i is high. When the last test passes, the block enters user state.
- R4: The first test whose result differs from its expected value moves the block to error. It sets the status code to the failing index plus 1, and no further test is run (kat_run_o goes low).
- R5: In user state both data enables are high. A conditional-test failure strobe moves the block to error with status code 15.
- R6: In error state, start, mode-change, return-for-analysis, service and test-handshake inputs have no effect. The state, status code and enables stay unchanged, and only a reset leaves this state. After the reset, a start pulse runs the self-tests again from index 0.
- R7: A mode-change request in user state raises clear_o for exactly CLR_CYCLES cycles, and during that time the mode output keeps its old value. The requested mode value appears on the mode output only when the clear has finished. The block then enters power-on and runs the self-tests again.
- R8: A service request is accepted (svc_accept_o high in the same cycle) only in user state while the gate is not busy. After an acceptance, svc_busy_o is high and further requests are rejected until svc_done_i is seen.
- R9: A return-for-analysis request in user state moves the block to state 5. There both enables are low, and the block stays in that state until reset, whatever the other inputs do.
- R10: When several user-state events arrive in the same cycle, a conditional-test failure wins over return-for-analysis, and return-for-analysis wins over mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Power-on pulse |
| kat_done_i | input | 1 | Current known-answer test has produced its result |
| kat_result_i | input | DATA_W | Computed test result |
| kat_expect_i | input | DATA_W | Stored expected value for the current test |
| cond_fail_i | input | 1 | Conditional test failure strobe |
| mode_req_i | input | 1 | Mode-change request |
| mode_val_i | input | 1 | Requested mode value |
| rma_req_i | input | 1 | Return-for-analysis request |
| svc_req_i | input | 1 | Service request |
| svc_done_i | input | 1 | Current service finished |
| state_o | output | 3 | Current operational state code |
| status_o | output | 4 | 0 = OK, 1..14 = failing power-up test index + 1, 15 = conditional failure |
| kat_run_o | output | 1 | Self-test sequence active |
| kat_idx_o | output | IDX_W | Index of the test being run |
| din_en_o | output | 1 | Data input path enabled |
| dout_en_o | output | 1 | Data output path enabled |
| svc_accept_o | output | 1 | Service request accepted this cycle |
| svc_busy_o | output | 1 | A service is in progress |
| clear_o | output | 1 | Stored secrets being cleared |
| mode_o | output | 1 | Current mode of operation |

## Verification
The bench builds the block with three tests, an 8-bit result width and a three-cycle secret clear. With these values it can reach a failure at the first, a middle and the last test index, so the status codes 1 through 3 all appear, and the clear window can be counted cycle by cycle. The short sequence also makes it cheap to reach user state many times. This lets the bench cover the conditional-failure path, the return-for-analysis path, the busy-gated service handshake, the priority between simultaneous events, and the rerun of the self-tests after both a reset and a mode change.

// File: rtl/secmod_pkg.sv
// Shared types for the operational state controller.
package secmod_pkg;
    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_PWRON    = 3'd1,
        ST_SELFTEST = 3'd2,
        ST_USER     = 3'd3,
        ST_ERROR    = 3'd4,
        ST_RMA      = 3'd5,
        ST_CLEAR    = 3'd6
    } op_state_e;

    localparam int unsigned STATUS_W = 4;
    localparam logic [STATUS_W-1:0] CODE_OK   = 4'd0;
    localparam logic [STATUS_W-1:0] CODE_COND = 4'd15;
endpackage

// File: rtl/secmod_kat_seq.sv
// Known-answer test sequencer. It walks the test index from 0 to the
// last index. A test passes when the computed result equals the expected value.
// Assumes: done_i is a one-cycle strobe per test; restart holds index at 0.
module secmod_kat_seq #(
    parameter int unsigned NUM_TESTS = 4,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned IDX_W    = (NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              active,
    input  logic              done_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic [DATA_W-1:0] expect_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              fail_o,
    output logic              all_pass_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TESTS - 1);

    logic [IDX_W-1:0] idx_q;
    logic             step;
    logic             match;

    // Judge the current test when its result arrives.
    always_comb begin
        step       = active && done_i;
        match      = (result_i == expect_i);
        fail_o     = step && !match;
        all_pass_o = step && match && (idx_q == LAST);
    end

    // Advance to the next test after a pass.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            idx_q <= '0;
        end else if (step && match && (idx_q != LAST)) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o = idx_q;

    a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST);
    a_r3_idx_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(idx_q) && (idx_q != '0)) |-> (idx_q == IDX_W'($past(idx_q) + 1'b1)));
endmodule

// File: rtl/secmod_svc_gate.sv
// Single-slot service gate. It accepts one request when allowed and
// not busy, and holds busy until the service reports done.
// Assumes: dropping allow abandons any service in flight.
module secmod_svc_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic req_i,
    input  logic done_i,
    output logic accept_o,
    output logic busy_o
);
    logic busy_q;

    // Accept only into an idle slot.
    always_comb accept_o = allow && req_i && !busy_q;

    // Track the service in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || !allow) begin
            busy_q <= 1'b0;
        end else if (accept_o) begin
            busy_q <= 1'b1;
        end else if (done_i) begin
            busy_q <= 1'b0;
        end
    end

    assign busy_o = busy_q;

    a_r8_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !accept_o);
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && allow) |=> (busy_o || !$past(allow)));
endmodule

// File: rtl/secmod_clr_timer.sv
// Secret-clear window timer. While run is high it counts cycles and
// flags the last cycle of a CLR_CYCLES-long window.
// Assumes: run stays high until done is seen, then drops.
module secmod_clr_timer #(
    parameter int unsigned CLR_CYCLES = 8,
    localparam int unsigned CNT_W     = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count the cycles of the current clear window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final cycle of the window.
    always_comb done_o = run && (cnt_q == CNT_W'(CLR_CYCLES - 1));

    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CLR_CYCLES - 1));
endmodule

// File: rtl/secmod_state_ctrl.sv
// Operational state controller for a cryptographic module. It sequences
// off -> power-on -> self-test -> user, and can go on to error, return-for-analysis
// or secret-clear and reboot. It gates the data paths per state.
// Assumes: NUM_TESTS <= 14 so that every failing index fits the status code.
module secmod_state_ctrl
    import secmod_pkg::*;
#(
    parameter int unsigned NUM_TESTS  = 4,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CLR_CYCLES = 8,
    localparam int unsigned IDX_W     = (NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                kat_done_i,
    input  logic [DATA_W-1:0]   kat_result_i,
    input  logic [DATA_W-1:0]   kat_expect_i,
    input  logic                cond_fail_i,
    input  logic                mode_req_i,
    input  logic                mode_val_i,
    input  logic                rma_req_i,
    input  logic                svc_req_i,
    input  logic                svc_done_i,
    output logic [2:0]          state_o,
    output logic [STATUS_W-1:0] status_o,
    output logic                kat_run_o,
    output logic [IDX_W-1:0]    kat_idx_o,
    output logic                din_en_o,
    output logic                dout_en_o,
    output logic                svc_accept_o,
    output logic                svc_busy_o,
    output logic                clear_o,
    output logic                mode_o
);
    op_state_e             state_q;
    logic [STATUS_W-1:0]   status_q;
    logic                  mode_q;
    logic                  mode_pend_q;
    logic                  kat_fail;
    logic                  kat_all_pass;
    logic                  clr_done;
    logic                  in_user;

    always_comb in_user = (state_q == ST_USER);

    secmod_kat_seq #(.NUM_TESTS(NUM_TESTS), .DATA_W(DATA_W)) u_kat (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (state_q == ST_PWRON),
        .active     (state_q == ST_SELFTEST),
        .done_i     (kat_done_i),
        .result_i   (kat_result_i),
        .expect_i   (kat_expect_i),
        .idx_o      (kat_idx_o),
        .fail_o     (kat_fail),
        .all_pass_o (kat_all_pass)
    );

    secmod_svc_gate u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .allow    (in_user),
        .req_i    (svc_req_i),
        .done_i   (svc_done_i),
        .accept_o (svc_accept_o),
        .busy_o   (svc_busy_o)
    );

    secmod_clr_timer #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_CLEAR),
        .done_o (clr_done)
    );

    // Main state sequence, status latch and mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_OFF;
            status_q    <= CODE_OK;
            mode_q      <= 1'b0;
            mode_pend_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: if (start_i) state_q <= ST_PWRON;
                ST_PWRON: begin
                    status_q <= CODE_OK;
                    state_q  <= ST_SELFTEST;
                end
                ST_SELFTEST: begin
                    if (kat_fail) begin
                        status_q <= STATUS_W'(kat_idx_o) + 4'd1;
                        state_q  <= ST_ERROR;
                    end else if (kat_all_pass) begin
                        state_q <= ST_USER;
                    end
                end
                ST_USER: begin
                    if (cond_fail_i) begin
                        status_q <= CODE_COND;
                        state_q  <= ST_ERROR;
                    end else if (rma_req_i) begin
                        state_q <= ST_RMA;
                    end else if (mode_req_i) begin
                        mode_pend_q <= mode_val_i;
                        state_q     <= ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    if (clr_done) begin
                        mode_q  <= mode_pend_q;
                        state_q <= ST_PWRON;
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    // Drive outputs from the registered state.
    always_comb begin
        state_o   = state_q;
        status_o  = status_q;
        kat_run_o = (state_q == ST_SELFTEST);
        din_en_o  = in_user;
        dout_en_o = in_user;
        clear_o   = (state_q == ST_CLEAR);
        mode_o    = mode_q;
    end

    a_r2_user_only_after_selftest: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && $past(state_o) != 3'd3) |-> ($past(state_o) == 3'd2));
    a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |=> (state_o == 3'd4 && $stable(status_o)));
    a_r4_error_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |-> (status_o != 4'd0));
    a_r7_mode_changes_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> ($past(clear_o) && state_o == 3'd1));
    a_r9_rma_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5) |=> (state_o == 3'd5));
    a_r8_accept_needs_paths: assert property (@(posedge clk) disable iff (!rst_n)
        svc_accept_o |-> (din_en_o && dout_en_o));
endmodule

// File: tb/secmod_state_ctrl_test.sv
module secmod_state_ctrl_test;
    localparam int NT = 3;
    localparam int DW = 8;
    localparam int CC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, kat_done_i = 0, cond_fail_i = 0, mode_req_i = 0;
    logic mode_val_i = 0, rma_req_i = 0, svc_req_i = 0, svc_done_i = 0;
    logic [DW-1:0] kat_result_i = '0, kat_expect_i = '0;
    logic [2:0] state_o;
    logic [3:0] status_o;
    logic kat_run_o, din_en_o, dout_en_o, svc_accept_o, svc_busy_o, clear_o, mode_o;
    logic [1:0] kat_idx_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    secmod_state_ctrl #(.NUM_TESTS(NT), .DATA_W(DW), .CLR_CYCLES(CC)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kat_done_i(kat_done_i),
        .kat_result_i(kat_result_i), .kat_expect_i(kat_expect_i),
        .cond_fail_i(cond_fail_i), .mode_req_i(mode_req_i), .mode_val_i(mode_val_i),
        .rma_req_i(rma_req_i), .svc_req_i(svc_req_i), .svc_done_i(svc_done_i),
        .state_o(state_o), .status_o(status_o), .kat_run_o(kat_run_o),
        .kat_idx_o(kat_idx_o), .din_en_o(din_en_o), .dout_en_o(dout_en_o),
        .svc_accept_o(svc_accept_o), .svc_busy_o(svc_busy_o), .clear_o(clear_o),
        .mode_o(mode_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic power_up();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 power-on state", state_o, 1);
        chk("R2 no din in power-on", din_en_o, 0);
        @(negedge clk);
        chk("R2 self-test entered", state_o, 2);
        chk("R2 test running", kat_run_o, 1);
    endtask

    task automatic one_test(input bit pass);
        kat_expect_i = 8'hA5;
        kat_result_i = pass ? 8'hA5 : 8'hA4;
        kat_done_i   = 1'b1;
        @(negedge clk);
        kat_done_i   = 1'b0;
    endtask

    task automatic to_user();
        do_reset();
        power_up();
        for (int i = 0; i < NT; i++) one_test(1'b1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 state off", state_o, 0);
        chk("R1 status ok", status_o, 0);
        chk("R1 din off", din_en_o, 0);
        chk("R1 dout off", dout_en_o, 0);
        chk("R1 busy low", svc_busy_o, 0);
        chk("R1 mode 0", mode_o, 0);
    endtask

    task automatic t_all_pass();
        do_reset();
        power_up();
        for (int i = 0; i < NT; i++) begin
            chk("R3 index order", kat_idx_o, i);
            chk("R3 still in self-test", state_o, 2);
            chk("R2 no dout in self-test", dout_en_o, 0);
            svc_req_i = 1'b1;
            #1 chk("R2 no service in self-test", svc_accept_o, 0);
            svc_req_i = 1'b0;
            one_test(1'b1);
        end
        chk("R3 user after last pass", state_o, 3);
        chk("R5 din enabled", din_en_o, 1);
        chk("R5 dout enabled", dout_en_o, 1);
        chk("R3 status ok", status_o, 0);
    endtask

    task automatic t_fail_at(input int idx);
        do_reset();
        power_up();
        for (int i = 0; i < idx; i++) one_test(1'b1);
        chk("R4 index before fail", kat_idx_o, idx);
        one_test(1'b0);
        chk("R4 error state", state_o, 4);
        chk("R4 code is index+1", status_o, idx + 1);
        chk("R4 sequence aborted", kat_run_o, 0);
    endtask

    task automatic t_error_sticky();
        t_fail_at(1);
        start_i = 1; mode_req_i = 1; rma_req_i = 1; svc_req_i = 1;
        kat_done_i = 1; kat_result_i = 8'hA5; kat_expect_i = 8'hA5;
        #1 chk("R6 no accept in error", svc_accept_o, 0);
        repeat (3) @(negedge clk);
        start_i = 0; mode_req_i = 0; rma_req_i = 0; svc_req_i = 0; kat_done_i = 0;
        chk("R6 error held", state_o, 4);
        chk("R6 status held", status_o, 2);
        chk("R6 din off", din_en_o, 0);
        chk("R6 dout off", dout_en_o, 0);
        do_reset();
        chk("R6 reset leaves error", state_o, 0);
        power_up();
        chk("R6 tests rerun from 0", kat_idx_o, 0);
    endtask

    task automatic t_cond_fail();
        to_user();
        cond_fail_i = 1'b1;
        @(negedge clk);
        cond_fail_i = 1'b0;
        chk("R5 cond fail -> error", state_o, 4);
        chk("R5 cond code 15", status_o, 15);
        chk("R5 paths closed", din_en_o, 0);
    endtask

    task automatic t_service();
        to_user();
        svc_req_i = 1'b1;
        #1 chk("R8 first request accepted", svc_accept_o, 1);
        @(negedge clk);
        chk("R8 busy set", svc_busy_o, 1);
        chk("R8 second request rejected", svc_accept_o, 0);
        svc_req_i = 1'b0;
        svc_done_i = 1'b1;
        @(negedge clk);
        svc_done_i = 1'b0;
        chk("R8 busy cleared", svc_busy_o, 0);
        svc_req_i = 1'b1;
        #1 chk("R8 accepted again", svc_accept_o, 1);
        @(negedge clk);
        svc_req_i = 1'b0;
    endtask

    task automatic t_mode();
        to_user();
        mode_val_i = 1'b1;
        mode_req_i = 1'b1;
        @(negedge clk);
        mode_req_i = 1'b0;
        for (int i = 0; i < CC; i++) begin
            chk("R7 clear active", clear_o, 1);
            chk("R7 mode held during clear", mode_o, 0);
            chk("R7 paths closed in clear", dout_en_o, 0);
            @(negedge clk);
        end
        chk("R7 clear ended", clear_o, 0);
        chk("R7 reboot to power-on", state_o, 1);
        chk("R7 mode updated", mode_o, 1);
        @(negedge clk);
        chk("R7 self-test rerun", state_o, 2);
        chk("R7 index restarted", kat_idx_o, 0);
        mode_val_i = 1'b0;
    endtask

    task automatic t_rma();
        to_user();
        rma_req_i = 1'b1;
        @(negedge clk);
        rma_req_i = 1'b0;
        chk("R9 rma state", state_o, 5);
        chk("R9 din off", din_en_o, 0);
        start_i = 1; mode_req_i = 1; cond_fail_i = 1;
        repeat (2) @(negedge clk);
        start_i = 0; mode_req_i = 0; cond_fail_i = 0;
        chk("R9 rma held", state_o, 5);
        chk("R9 no clear", clear_o, 0);
    endtask

    task automatic t_priority();
        to_user();
        cond_fail_i = 1; rma_req_i = 1; mode_req_i = 1;
        @(negedge clk);
        cond_fail_i = 0; rma_req_i = 0; mode_req_i = 0;
        chk("R10 cond fail wins", state_o, 4);
        chk("R10 cond code", status_o, 15);
        to_user();
        rma_req_i = 1; mode_req_i = 1; mode_val_i = 1;
        @(negedge clk);
        rma_req_i = 0; mode_req_i = 0; mode_val_i = 0;
        chk("R10 rma beats mode", state_o, 5);
        chk("R10 mode untouched", mode_o, 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_all_pass();
        t_fail_at(0);
        t_fail_at(NT - 1);
        t_error_sticky();
        t_cond_fail();
        t_service();
        t_mode();
        t_rma();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule